// File: doc/BRIEF.md
# Pixel Pack, Expand and Merge Unit

This block is the pixel-formatting datapath of a graphics-capable execution pipe. It takes two 64-bit source operands, a 3-bit operation code and a 5-bit scale value, and it produces a 64-bit result. Three of its operations narrow fixed-point lanes to pixel-sized fields. Each lane is shifted left by the scale, arithmetically shifted right by a fixed amount that depends on the operation, and then clamped. The other two operations widen bytes into 16-bit lanes or interleave the bytes of two words.

The datapath itself is combinational. With the default `REG_OUT = 1`, the result is captured one cycle after a valid strobe and is marked by an output valid flag. With `REG_OUT = 0`, the result and the valid flag pass straight through. The scale comes from a status field held outside the block.

Operation codes on `op_sel`:

| Code | Operation |
|------|-----------|
| 0 | pack16 |
| 1 | pack32 |
| 2 | packfix |
| 3 | expand |
| 4 | merge |
| 5 to 7 | reserved |

Top module: `pxfmt_unit`

## Requirements
- R1: With op_sel = 0 (pack16), the four signed 16-bit lanes of src_b are each processed the same way. Lane k is shifted left by scale[3:0], arithmetically shifted right by 7, and clamped to 0..255. The clamped value becomes result byte k, and scale[4] has no effect.
- R2: With op_sel = 1 (pack32), the result starts as src_a shifted left by 8, with bytes 0 and 4 cleared. Each signed 32-bit half w of src_b is shifted left by the full 5-bit scale, arithmetically shifted right by 23, and clamped to 0..255. The clamped value is placed in byte 4w.
- R3: With op_sel = 2 (packfix), each signed 32-bit half w of src_b is shifted left by scale, arithmetically shifted right by 16, and saturated to -32768..32767. Half 0 fills result[15:0] and half 1 fills result[31:16].
- R4: With op_sel = 3 (expand), byte k of src_b[31:0] is shifted left by 4 into 16-bit lane k, and the lane's top nibble is zero. src_b[63:32] has no effect.
- R5: With op_sel = 4 (merge), result byte 2k takes byte k of src_b and result byte 2k+1 takes byte k of src_a, for k = 0..3.
- R6: For pack16 and packfix, result[63:32] is zero.
- R7: The left shift by the scale keeps every bit before the right shift and the clamp. For example, a lane value of 1 with the largest scale saturates high instead of wrapping.
- R8: Reserved codes 5, 6 and 7 give an all-zero result.
- R9: When REG_OUT = 1, out_valid equals in_valid one cycle earlier, and result shows the operation strobed in that earlier cycle. While in_valid is low, result holds its value.
- R10: An asynchronous active-low reset clears result and out_valid.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Operand strobe |
| op_sel | input | 3 | Operation code (0..4, 5 to 7 reserved) |
| scale | input | 5 | Scale amount; pack16 uses bits [3:0] |
| src_a | input | 64 | First operand |
| src_b | input | 64 | Second operand |
| out_valid | output | 1 | Result valid |
| result | output | 64 | Formatted result |

## Verification
The embedded assertions cover the properties that hold for any operand values, checked on every cycle:
- the valid flag follows the strobe;
- the result holds while idle;
- the upper half is zero after the 32-bit packs;
- expanded lanes carry zero nibbles;
- the low merged bytes come from the right operand;
- reserved codes give zero.

The clamp arithmetic can only be shown by the directed scenarios. These cover the exact packed values at both saturation limits, the loss-free wide shift at the largest scales, the unused scale bit in pack16, and the reset in the middle of a run. The bench compares each of these against values computed from the requirements.

// File: rtl/pxfmt_pkg.sv
package pxfmt_pkg;
  localparam int DATA_W  = 64;
  localparam int HALF_W  = DATA_W / 2;
  localparam int BYTE_W  = 8;
  localparam int H16_W   = 16;
  localparam int OP_W    = 3;

  typedef enum logic [OP_W-1:0] {
    OP_PACK16  = 3'd0,
    OP_PACK32  = 3'd1,
    OP_PACKFIX = 3'd2,
    OP_EXPAND  = 3'd3,
    OP_MERGE   = 3'd4
  } pxfmt_op_e;
endpackage

// File: rtl/pxfmt_sat_lane.sv
module pxfmt_sat_lane #(
  parameter int IN_W       = 16,
  parameter int SCL_W      = 4,
  parameter int RSH        = 7,
  parameter int OUT_W      = 8,
  parameter bit SIGNED_OUT = 1'b0
) (
  input  logic [IN_W-1:0]  lane_in,
  input  logic [SCL_W-1:0] scale,
  output logic [OUT_W-1:0] lane_out
);
  // wide enough that the largest left shift loses nothing
  localparam int WIDE = IN_W + (1 << SCL_W);
  localparam logic signed [WIDE-1:0] HI_LIM =
    SIGNED_OUT ? WIDE'((1 << (OUT_W-1)) - 1) : WIDE'((1 << OUT_W) - 1);
  localparam logic signed [WIDE-1:0] LO_LIM =
    SIGNED_OUT ? WIDE'(-(1 << (OUT_W-1))) : WIDE'(0);

  logic signed [WIDE-1:0] ext_v, shl_v, shr_v;

  always_comb begin
    ext_v = {{(WIDE-IN_W){lane_in[IN_W-1]}}, lane_in};
    shl_v = ext_v <<< scale;
    shr_v = shl_v >>> RSH;
    if (shr_v < LO_LIM)      lane_out = LO_LIM[OUT_W-1:0];
    else if (shr_v > HI_LIM) lane_out = HI_LIM[OUT_W-1:0];
    else                     lane_out = shr_v[OUT_W-1:0];
  end
endmodule

// File: rtl/pxfmt_byte_route.sv
module pxfmt_byte_route #(
  parameter int LANES  = 4,
  parameter int BYTE_W = 8,
  parameter int EXP_SH = 4
) (
  input  logic [LANES*BYTE_W-1:0]   a_lo,
  input  logic [LANES*BYTE_W-1:0]   b_lo,
  output logic [2*LANES*BYTE_W-1:0] expand_out,
  output logic [2*LANES*BYTE_W-1:0] merge_out
);
  localparam int LANE_W = 2 * BYTE_W;
  localparam int TOP_W  = LANE_W - BYTE_W - EXP_SH;

  for (genvar k = 0; k < LANES; k++) begin : g_lane
    assign expand_out[k*LANE_W +: LANE_W] =
      {{TOP_W{1'b0}}, b_lo[k*BYTE_W +: BYTE_W], {EXP_SH{1'b0}}};
    assign merge_out[k*LANE_W +: BYTE_W]          = b_lo[k*BYTE_W +: BYTE_W];
    assign merge_out[k*LANE_W + BYTE_W +: BYTE_W] = a_lo[k*BYTE_W +: BYTE_W];
  end
endmodule

// File: rtl/pxfmt_unit.sv
module pxfmt_unit
  import pxfmt_pkg::*;
#(
  parameter int SCALE_W = 5,
  parameter bit REG_OUT = 1'b1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [OP_W-1:0]   op_sel,
  input  logic [SCALE_W-1:0] scale,
  input  logic [DATA_W-1:0] src_a,
  input  logic [DATA_W-1:0] src_b,
  output logic              out_valid,
  output logic [DATA_W-1:0] result
);
  localparam int P16_LANES = DATA_W / H16_W;
  localparam int P32_LANES = DATA_W / HALF_W;
  localparam int P16_SCL_W = SCALE_W - 1;
  localparam int RT_LANES  = HALF_W / BYTE_W;
  localparam logic [DATA_W-1:0] P32_CLR_MASK =
    ~({{(HALF_W-BYTE_W){1'b0}}, {BYTE_W{1'b1}}, {(HALF_W-BYTE_W){1'b0}}, {BYTE_W{1'b1}}});

  logic [P16_LANES*BYTE_W-1:0] pk16_bytes;
  logic [P32_LANES*BYTE_W-1:0] pk32_bytes;
  logic [P32_LANES*H16_W-1:0]  pkfx_words;
  logic [DATA_W-1:0]           expand_v, merge_v, pk32_v;
  logic [DATA_W-1:0]           result_d;

  // four 16-bit lanes to unsigned bytes
  for (genvar k = 0; k < P16_LANES; k++) begin : g_p16
    pxfmt_sat_lane #(.IN_W(H16_W), .SCL_W(P16_SCL_W), .RSH(7),
                     .OUT_W(BYTE_W), .SIGNED_OUT(1'b0)) u_lane (
      .lane_in (src_b[k*H16_W +: H16_W]),
      .scale   (scale[P16_SCL_W-1:0]),
      .lane_out(pk16_bytes[k*BYTE_W +: BYTE_W])
    );
  end

  // two 32-bit lanes: unsigned byte pack and signed 16-bit fixed pack
  for (genvar w = 0; w < P32_LANES; w++) begin : g_p32
    pxfmt_sat_lane #(.IN_W(HALF_W), .SCL_W(SCALE_W), .RSH(23),
                     .OUT_W(BYTE_W), .SIGNED_OUT(1'b0)) u_byte (
      .lane_in (src_b[w*HALF_W +: HALF_W]),
      .scale   (scale),
      .lane_out(pk32_bytes[w*BYTE_W +: BYTE_W])
    );
    pxfmt_sat_lane #(.IN_W(HALF_W), .SCL_W(SCALE_W), .RSH(16),
                     .OUT_W(H16_W), .SIGNED_OUT(1'b1)) u_fix (
      .lane_in (src_b[w*HALF_W +: HALF_W]),
      .scale   (scale),
      .lane_out(pkfx_words[w*H16_W +: H16_W])
    );
  end

  pxfmt_byte_route #(.LANES(RT_LANES), .BYTE_W(BYTE_W), .EXP_SH(4)) u_route (
    .a_lo      (src_a[HALF_W-1:0]),
    .b_lo      (src_b[HALF_W-1:0]),
    .expand_out(expand_v),
    .merge_out (merge_v)
  );

  always_comb begin
    pk32_v = (src_a << BYTE_W) & P32_CLR_MASK;
    for (int w = 0; w < P32_LANES; w++)
      pk32_v[w*HALF_W +: BYTE_W] = pk32_bytes[w*BYTE_W +: BYTE_W];
  end

  always_comb begin
    result_d = '0;
    case (pxfmt_op_e'(op_sel))
      OP_PACK16:  result_d[HALF_W-1:0] = pk16_bytes;
      OP_PACK32:  result_d = pk32_v;
      OP_PACKFIX: result_d[HALF_W-1:0] = pkfx_words;
      OP_EXPAND:  result_d = expand_v;
      OP_MERGE:   result_d = merge_v;
      default:    result_d = '0;
    endcase
  end

  if (REG_OUT) begin : g_reg
    logic              vld_q, vld_n;
    logic [DATA_W-1:0] res_q, res_n;

    always_comb begin
      vld_n = in_valid;
      res_n = in_valid ? result_d : res_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        vld_q <= 1'b0;
        res_q <= '0;
      end else begin
        vld_q <= vld_n;
        res_q <= res_n;
      end
    end

    assign out_valid = vld_q;
    assign result    = res_q;

    // R9
    valid_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid |=> out_valid);
    // R9
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !in_valid |=> (!out_valid && $stable(result)));
    // R6
    upper_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && (op_sel == OP_PACK16 || op_sel == OP_PACKFIX))
        |=> (result[DATA_W-1:HALF_W] == '0));
    // R4
    expand_nibble_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && op_sel == OP_EXPAND)
        |=> ((result & 64'hF00F_F00F_F00F_F00F) == '0));
    // R5
    merge_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && op_sel == OP_MERGE)
        |=> (result[7:0] == $past(src_b[7:0]) && result[15:8] == $past(src_a[7:0])));
    // R8
    reserved_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && op_sel > OP_MERGE) |=> (result == '0));
  end else begin : g_comb
    assign out_valid = in_valid;
    assign result    = result_d;
  end
endmodule

// File: tb/pxfmt_unit_tb.sv
module pxfmt_unit_tb_top;
  logic        clk;
  logic        rst_n;
  logic        in_valid;
  logic [2:0]  op_sel;
  logic [4:0]  scale;
  logic [63:0] src_a, src_b;
  logic        out_valid;
  logic [63:0] result;
  int          total = 0;
  int          bad = 0;
  bit          done = 0;

  pxfmt_unit dut_i (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .op_sel(op_sel),
    .scale(scale), .src_a(src_a), .src_b(src_b),
    .out_valid(out_valid), .result(result)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  function automatic longint clampv(longint v, longint lo, longint hi);
    if (v < lo) return lo;
    if (v > hi) return hi;
    return v;
  endfunction

  function automatic logic [63:0] model(logic [2:0] op, logic [4:0] sc,
                                        logic [63:0] a, logic [63:0] b);
    logic [63:0] r;
    longint v;
    r = '0;
    case (op)
      3'd0: for (int k = 0; k < 4; k++) begin
        v = longint'($signed(b[16*k +: 16]));
        v = (v <<< sc[3:0]) >>> 7;
        r[8*k +: 8] = 8'(clampv(v, 0, 255));
      end
      3'd1: begin
        r = (a << 8) & ~64'h0000_00FF_0000_00FF;
        for (int w = 0; w < 2; w++) begin
          v = longint'($signed(b[32*w +: 32]));
          v = (v <<< sc) >>> 23;
          r[32*w +: 8] = 8'(clampv(v, 0, 255));
        end
      end
      3'd2: for (int w = 0; w < 2; w++) begin
        v = longint'($signed(b[32*w +: 32]));
        v = (v <<< sc) >>> 16;
        r[16*w +: 16] = 16'(clampv(v, -32768, 32767));
      end
      3'd3: for (int k = 0; k < 4; k++) r[16*k +: 16] = {4'h0, b[8*k +: 8], 4'h0};
      3'd4: for (int k = 0; k < 4; k++) begin
        r[16*k +: 8]     = b[8*k +: 8];
        r[16*k + 8 +: 8] = a[8*k +: 8];
      end
      default: r = '0;
    endcase
    return r;
  endfunction

  task automatic check(string req, logic [63:0] act, logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  // strobe one operation, sample after the capturing edge
  task automatic run_op(logic [2:0] op, logic [4:0] sc,
                        logic [63:0] a, logic [63:0] b, output logic [63:0] got);
    @(negedge clk);
    op_sel = op; scale = sc; src_a = a; src_b = b; in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    check("R9 valid", {63'd0, out_valid}, 64'd1);
    got = result;
  endtask

  task automatic t_reset();
    check("R10 reset result", result, 64'd0);
    check("R10 reset valid", {63'd0, out_valid}, 64'd0);
  endtask

  task automatic t_pack16();
    logic [63:0] g;
    logic [63:0] b;
    run_op(3'd0, 5'd0, 64'hFFFF_FFFF_FFFF_FFFF, 64'h0000_0400_FF00_0100, g);
    check("R1 pack16 basic", g, 64'h0000_0000_0008_0002);
    b = 64'h0123_7FFF_8000_00C5;
    run_op(3'd0, 5'd3, 64'd0, b, g);
    check("R1 pack16 mixed", g, model(3'd0, 5'd3, 64'd0, b));
    run_op(3'd0, 5'b10011, 64'd0, b, g);
    check("R1 pack16 scale bit4 unused", g, model(3'd0, 5'd3, 64'd0, b));
    // R6 upper half zero although src_a is all ones
    run_op(3'd0, 5'd2, 64'hFFFF_FFFF_FFFF_FFFF, b, g);
    check("R6 pack16 upper zero", {32'd0, g[63:32]}, 64'd0);
  endtask

  task automatic t_pack32();
    logic [63:0] g;
    run_op(3'd1, 5'd0, 64'h1122_3344_5566_7788, 64'h0100_0000_0080_0000, g);
    check("R2 pack32 basic", g, 64'h2233_4402_6677_8801);
    run_op(3'd1, 5'd7, 64'hA5A5_A5A5_5A5A_5A5A, 64'hFFF0_0000_0003_1234, g);
    check("R2 pack32 scaled", g,
          model(3'd1, 5'd7, 64'hA5A5_A5A5_5A5A_5A5A, 64'hFFF0_0000_0003_1234));
  endtask

  task automatic t_packfix();
    logic [63:0] g;
    run_op(3'd2, 5'd0, 64'd0, 64'h8000_0000_7FFF_FFFF, g);
    check("R3 packfix limits s0", g, 64'h0000_0000_8000_7FFF);
    run_op(3'd2, 5'd1, 64'hFFFF_FFFF_0000_0000, 64'h8000_0000_7FFF_FFFF, g);
    check("R3 packfix saturate", g, 64'h0000_0000_8000_7FFF);
    run_op(3'd2, 5'd4, 64'd0, 64'hFFFF_F000_0001_2345, g);
    check("R3 packfix mid", g, 64'h0000_0000_FFFF_0012);
    check("R6 packfix upper zero", {32'd0, g[63:32]}, 64'd0);
  endtask

  task automatic t_expand_merge();
    logic [63:0] g;
    run_op(3'd3, 5'd9, 64'h1234_5678_9ABC_DEF0, 64'hDEAD_BEEF_A1B2_C3D4, g);
    check("R4 expand", g, 64'h0A10_0B20_0C30_0D40);
    run_op(3'd4, 5'd0, 64'hFFFF_FFFF_4433_2211, 64'hEEEE_EEEE_8877_6655, g);
    check("R5 merge", g, 64'h4488_3377_2266_1155);
  endtask

  task automatic t_wide_shift();
    logic [63:0] g;
    run_op(3'd0, 5'd15, 64'd0, 64'h0000_0000_0000_0001, g);
    check("R7 pack16 scale15", g, 64'h0000_0000_0000_00FF);
    run_op(3'd1, 5'd31, 64'd0, 64'h0000_0001_0000_0001, g);
    check("R7 pack32 scale31", g, 64'h0000_00FF_0000_00FF);
  endtask

  task automatic t_reserved();
    logic [63:0] g;
    for (int op = 5; op < 8; op++) begin
      run_op(3'(op), 5'd3, 64'hFFFF_FFFF_FFFF_FFFF, 64'h1234_5678_9ABC_DEF0, g);
      check("R8 reserved zero", g, 64'd0);
    end
  endtask

  task automatic t_hold_and_reset();
    logic [63:0] g;
    run_op(3'd4, 5'd0, 64'h0000_0000_0102_0304, 64'h0000_0000_0506_0708, g);
    @(negedge clk);
    src_a = '1; src_b = '1; op_sel = 3'd3;
    @(negedge clk);
    @(negedge clk);
    check("R9 idle hold", result, 64'h0105_0206_0307_0408);
    check("R9 idle valid low", {63'd0, out_valid}, 64'd0);
    rst_n = 1'b0;
    #3;
    check("R10 async reset result", result, 64'd0);
    @(negedge clk);
    rst_n = 1'b1;
    check("R10 async reset valid", {63'd0, out_valid}, 64'd0);
  endtask

  initial begin
    rst_n = 1'b0; in_valid = 1'b0; op_sel = '0; scale = '0; src_a = '0; src_b = '0;
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    t_pack16();
    t_pack32();
    t_packfix();
    t_expand_merge();
    t_wide_shift();
    t_reserved();
    t_hold_and_reset();
    if (!done) begin
      done = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      total++; bad++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule